// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block owns the stack pointer of a small processor with a 24-bit address space. It saves and restores return context through a memory port that moves one byte per cycle. A one-cycle command strobe selects one of five operations. Hardware interrupt entry and software trap entry both push a four-byte frame. A subroutine call pushes a return address that the caller supplies. Interrupt return pops a frame into PC and status. Subroutine return pops a frame into PC only.

An entry frame holds the current PC plus 2 in its three low bytes and the 8-bit status value in its top byte. A call frame holds the supplied address and a zero top byte. Every push first lowers the stack pointer by four and then writes the frame upward from the new pointer. Every pop reads four bytes upward from the pointer and then raises the pointer by four. The PC, status and pointer outputs change only when an operation completes, so a partly restored context is never visible.

Top module: `stack_frame_seq`

## Requirements
- R1: While `rst` is high and after its release, `sp_out` equals the `SP_INIT` parameter. `busy`, `done`, `pc_load`, `psr_load`, `mem_we` and `mem_re` are 0.
- R2: Opcode 0 (hardware interrupt) and opcode 1 (software trap) write four bytes on four consecutive cycles, one byte per cycle, at addresses SP-4+0 through SP-4+3. The bytes are, in order, (PC+2)[7:0], (PC+2)[15:8], (PC+2)[23:16] and the status input. The first write is on the cycle after the command is accepted.
- R3: After any push, `sp_out` equals the old SP minus 4. It changes in the cycle in which `done` is high and in no other cycle.
- R4: Opcode 3 (call) writes `cur_pc` unmodified as the low three bytes, least significant byte at the lowest address, and writes 0x00 at SP-4+3.
- R5: Opcode 2 (interrupt return) reads SP+0 through SP+3 on four consecutive cycles. It then loads `pc_out` with the first three bytes, least significant byte first, and `psr_out` with the fourth. `pc_load`, `psr_load` and `done` pulse together, and SP rises by 4.
- R6: Opcode 4 (subroutine return) loads `pc_out` from SP+0 through SP+2 and raises SP by 4. It leaves `psr_out` unchanged and keeps `psr_load` at 0.
- R7: SP arithmetic and the saved PC+2 wrap modulo 2^24. For example, a push from SP 0x000000 writes at 0xFFFFFC, and entry with PC 0xFFFFFF saves 0x000001.
- R8: A strobe that arrives while `busy` is high is ignored. Opcodes 5, 6 and 7 are ignored. An ignored strobe causes no memory access and no change to SP.
- R9: `busy` is high for 4 cycles on a push and 5 cycles on a pop, starting the cycle after acceptance. `done` is a one-cycle pulse in the first cycle with `busy` low. `mem_we` and `mem_re` are never high together.
- R10: `pc_out` and `psr_out` change only in a cycle in which their load strobe is high. During a pop they keep their earlier values until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 irq entry, 1 trap entry, 2 interrupt return, 3 call, 4 subroutine return |
| cur_pc | input | 24 | Current PC (entry) or return address (call) |
| cur_psr | input | 8 | Current status value |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| sp_out | output | 24 | Stack pointer |
| pc_out | output | 24 | Restored PC |
| pc_load | output | 1 | Pulse: `pc_out` updated |
| psr_out | output | 8 | Restored status |
| psr_load | output | 1 | Pulse: `psr_out` updated |
| mem_addr | output | 24 | Byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check a set of rules on every cycle:
- SP changes only with `done`, and `done` never lasts longer than one cycle or coincides with `busy`.
- Write and read strobes are exclusive, and back-to-back writes step the address by one.
- Memory is idle whenever `busy` is low.
- The PC and status outputs change only with their strobes, and a status load never occurs without a PC load.

Only the bench scenarios can show the frame contents and byte order, the value of PC+2, the zero top byte of a call frame, and round trips through nested frames. The same holds for wrap-around at both ends of the address space, the exact cycle counts, and that busy-time and undefined commands leave memory and SP untouched.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [2:0] {
    OP_IRQ  = 3'd0,
    OP_TRAP = 3'd1,
    OP_IRET = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP,
    ST_LAST
  } seq_state_e;

  function automatic logic op_is_push(input logic [2:0] op);
    return (op == OP_IRQ) || (op == OP_TRAP) || (op == OP_CALL);
  endfunction

  function automatic logic op_is_pop(input logic [2:0] op);
    return (op == OP_IRET) || (op == OP_RET);
  endfunction

endpackage

// File: rtl/stkseq_frame_pack.sv
module stkseq_frame_pack
  import stkseq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int STAT_W  = 8,
  parameter int PC_ADJ  = 2,
  localparam int FRAME_W = ADDR_W + STAT_W
) (
  input  logic [2:0]         op,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [STAT_W-1:0]  psr,
  output logic [FRAME_W-1:0] frame
);

  logic [ADDR_W-1:0] ret_addr;

  always_comb begin
    ret_addr = pc + ADDR_W'(PC_ADJ);
    if (op == OP_CALL) begin
      frame = {{STAT_W{1'b0}}, pc};
    end else begin
      frame = {psr, ret_addr};
    end
  end

endmodule

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter int              FRAME_W     = 32,
  parameter logic [ADDR_W-1:0] SP_INIT   = '0,
  localparam int             FRAME_BYTES = FRAME_W / 8,
  localparam int             IDX_W       = $clog2(FRAME_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [FRAME_W-1:0] frame_in,
  output logic [ADDR_W-1:0]  sp_q,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [7:0]         mem_wdata,
  output logic               busy,
  output logic               done,
  output logic               last_cyc,
  output logic [IDX_W-1:0]   idx_q,
  output logic [2:0]         op_q
);

  localparam logic [ADDR_W-1:0] FRAME_STEP = ADDR_W'(FRAME_BYTES);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(FRAME_BYTES - 1);

  seq_state_e         state;
  logic [FRAME_W-1:0] shift_q;
  logic               accept_push;
  logic               accept_pop;

  always_comb begin
    accept_push = (state == ST_IDLE) && cmd_valid && op_is_push(cmd_op);
    accept_pop  = (state == ST_IDLE) && cmd_valid && op_is_pop(cmd_op);
    last_cyc    = (state == ST_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sp_q      <= SP_INIT;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      idx_q     <= '0;
      op_q      <= '0;
      shift_q   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept_push) begin
            state     <= ST_PUSH;
            busy      <= 1'b1;
            idx_q     <= '0;
            op_q      <= cmd_op;
            mem_we    <= 1'b1;
            mem_addr  <= sp_q - FRAME_STEP;
            mem_wdata <= frame_in[7:0];
            shift_q   <= frame_in >> 8;
          end else if (accept_pop) begin
            state    <= ST_POP;
            busy     <= 1'b1;
            idx_q    <= '0;
            op_q     <= cmd_op;
            mem_re   <= 1'b1;
            mem_addr <= sp_q;
          end
        end
        ST_PUSH: begin
          if (idx_q == LAST_IDX) begin
            mem_we <= 1'b0;
            state  <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
            sp_q   <= sp_q - FRAME_STEP;
          end else begin
            idx_q     <= idx_q + 1'b1;
            mem_addr  <= mem_addr + ADDR_W'(1);
            mem_wdata <= shift_q[7:0];
            shift_q   <= shift_q >> 8;
          end
        end
        ST_POP: begin
          if (idx_q == LAST_IDX) begin
            mem_re <= 1'b0;
            state  <= ST_LAST;
          end else begin
            idx_q    <= idx_q + 1'b1;
            mem_addr <= mem_addr + ADDR_W'(1);
          end
        end
        ST_LAST: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
          sp_q  <= sp_q + FRAME_STEP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: strobes exclusive
  always_comb begin
    if (!rst) begin
      a_r9_we_re_excl: assert (!(mem_we && mem_re));
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r3_sp_only_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp_q) |-> done);

endmodule

// File: rtl/stkseq_restore.sv
module stkseq_restore
  import stkseq_pkg::*;
#(
  parameter int  ADDR_W   = 24,
  parameter int  STAT_W   = 8,
  parameter int  IDX_W    = 2,
  localparam int PC_BYTES = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_re,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [7:0]        mem_rdata,
  input  logic              last_cyc,
  input  logic [2:0]        op_q,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic [STAT_W-1:0] psr_out,
  output logic              psr_load
);

  logic              rd_valid;
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] pc_cat;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_idx   <= '0;
      pc_cat   <= '0;
    end else begin
      rd_valid <= mem_re;
      rd_idx   <= idx_q;
      for (int i = 0; i < PC_BYTES; i++) begin
        if (rd_valid && (rd_idx == IDX_W'(i))) begin
          pc_cat[i*8 +: 8] <= mem_rdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out   <= '0;
      psr_out  <= '0;
      pc_load  <= 1'b0;
      psr_load <= 1'b0;
    end else begin
      pc_load  <= 1'b0;
      psr_load <= 1'b0;
      if (last_cyc) begin
        pc_out  <= pc_cat;
        pc_load <= 1'b1;
        if (op_q == OP_IRET) begin
          psr_out  <= mem_rdata[STAT_W-1:0];
          psr_load <= 1'b1;
        end
      end
    end
  end

  a_r10_pc_only_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> pc_load);

  a_r10_psr_only_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(psr_out) |-> psr_load);

  a_r6_psr_needs_pc: assert property (@(posedge clk) disable iff (rst)
    psr_load |-> pc_load);

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import stkseq_pkg::*;
#(
  parameter int                ADDR_W  = 24,
  parameter int                STAT_W  = 8,
  parameter int                PC_ADJ  = 2,
  parameter logic [ADDR_W-1:0] SP_INIT = 24'h001000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [STAT_W-1:0] cur_psr,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] sp_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_load,
  output logic [STAT_W-1:0] psr_out,
  output logic              psr_load,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done
);

  localparam int FRAME_W     = ADDR_W + STAT_W;
  localparam int FRAME_BYTES = FRAME_W / 8;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  logic [FRAME_W-1:0] frame;
  logic               last_cyc;
  logic [IDX_W-1:0]   idx_q;
  logic [2:0]         op_q;

  stkseq_frame_pack #(
    .ADDR_W (ADDR_W),
    .STAT_W (STAT_W),
    .PC_ADJ (PC_ADJ)
  ) pack_i (
    .op    (cmd_op),
    .pc    (cur_pc),
    .psr   (cur_psr),
    .frame (frame)
  );

  stkseq_ctrl #(
    .ADDR_W  (ADDR_W),
    .FRAME_W (FRAME_W),
    .SP_INIT (SP_INIT)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .frame_in  (frame),
    .sp_q      (sp_out),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .last_cyc  (last_cyc),
    .idx_q     (idx_q),
    .op_q      (op_q)
  );

  stkseq_restore #(
    .ADDR_W (ADDR_W),
    .STAT_W (STAT_W),
    .IDX_W  (IDX_W)
  ) restore_i (
    .clk       (clk),
    .rst       (rst),
    .mem_re    (mem_re),
    .idx_q     (idx_q),
    .mem_rdata (mem_rdata),
    .last_cyc  (last_cyc),
    .op_q      (op_q),
    .pc_out    (pc_out),
    .pc_load   (pc_load),
    .psr_out   (psr_out),
    .psr_load  (psr_load)
  );

endmodule

// File: tb/stack_frame_seq_tb_top.sv
`timescale 1ns/1ps
module stack_frame_seq_tb_top;

  localparam logic [23:0] SPI = 24'h000008;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [23:0] cur_pc = '0;
  logic [7:0]  cur_psr = '0;
  logic [7:0]  mem_rdata = '0;
  logic [23:0] sp_out, pc_out, mem_addr;
  logic [7:0]  psr_out, mem_wdata;
  logic        pc_load, psr_load, mem_we, mem_re, busy, done;

  stack_frame_seq #(.SP_INIT(SPI)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cur_pc(cur_pc), .cur_psr(cur_psr), .mem_rdata(mem_rdata),
    .sp_out(sp_out), .pc_out(pc_out), .pc_load(pc_load),
    .psr_out(psr_out), .psr_load(psr_load), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  int checks = 0;
  int fails  = 0;

  logic [23:0] w_addr [8];
  logic [7:0]  w_data [8];
  logic [23:0] r_addr [8];
  int nw, nr, nb, ncyc;
  bit got_pcl, got_psrl, partial, got_done;
  logic [23:0] exp_sp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Issue one command, keep cmd_valid for 'hold' cycles, and watch until done.
  task automatic run_cmd(input logic [2:0] op, input logic [23:0] pc, input logic [7:0] psr, input int hold);
    logic [23:0] pc0;
    logic [7:0]  psr0;
    nw = 0; nr = 0; nb = 0; ncyc = 0;
    got_pcl = 0; got_psrl = 0; partial = 0; got_done = 0;
    @(negedge clk);
    pc0 = pc_out; psr0 = psr_out;
    cmd_valid = 1'b1; cmd_op = op; cur_pc = pc; cur_psr = psr;
    while (!got_done && ncyc < 20) begin
      @(negedge clk);
      ncyc++;
      if (mem_we && nw < 8) begin w_addr[nw] = mem_addr; w_data[nw] = mem_wdata; nw++; end
      if (mem_re && nr < 8) begin r_addr[nr] = mem_addr; nr++; end
      if (busy) nb++;
      if (done) begin
        got_done = 1; got_pcl = pc_load; got_psrl = psr_load;
      end else if (pc_out !== pc0 || psr_out !== psr0) begin
        partial = 1;
      end
      if (ncyc >= hold) cmd_valid = 1'b0;
      else cmd_op = 3'd2;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic do_push(input logic [2:0] op, input logic [23:0] pc, input logic [7:0] psr, input int hold);
    logic [31:0] fr;
    logic [23:0] base;
    fr = (op == 3'd3) ? {8'h00, pc} : {psr, pc + 24'd2};
    base = exp_sp - 24'd4;
    run_cmd(op, pc, psr, hold);
    chk(nw == 4 && nr == 0, "R2 write count", 32'(nw), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk(w_addr[i] == base + 24'(i), (op == 3'd3) ? "R4 addr" : "R2 addr", 32'(w_addr[i]), 32'(base + 24'(i)));
      chk(w_data[i] == fr[i*8 +: 8], (op == 3'd3) ? "R4 data" : "R2 data", 32'(w_data[i]), 32'(fr[i*8 +: 8]));
    end
    chk(ncyc == 5 && nb == 4, "R9 push timing", 32'(ncyc*16 + nb), 32'h54);
    chk(!got_pcl && !got_psrl, "R9 push no load", 32'(got_pcl), 32'd0);
    exp_sp = base;
    chk(sp_out == exp_sp, "R3 sp after push", 32'(sp_out), 32'(exp_sp));
  endtask

  task automatic do_pop(input logic [2:0] op, input logic [23:0] exp_pc, input logic [7:0] exp_psr);
    run_cmd(op, 24'h0, 8'h0, 1);
    chk(nr == 4 && nw == 0, "R5 read count", 32'(nr), 32'd4);
    for (int i = 0; i < 4; i++)
      chk(r_addr[i] == exp_sp + 24'(i), "R5 read addr", 32'(r_addr[i]), 32'(exp_sp + 24'(i)));
    chk(ncyc == 6 && nb == 5, "R9 pop timing", 32'(ncyc*16 + nb), 32'h65);
    chk(!partial, "R10 no partial restore", 32'(partial), 32'd0);
    chk(got_pcl && pc_out == exp_pc, "R5 pc restored", 32'(pc_out), 32'(exp_pc));
    if (op == 3'd2) begin
      chk(got_psrl && psr_out == exp_psr, "R5 psr restored", 32'(psr_out), 32'(exp_psr));
    end else begin
      chk(!got_psrl && psr_out == exp_psr, "R6 psr untouched", 32'(psr_out), 32'(exp_psr));
    end
    exp_sp = exp_sp + 24'd4;
    chk(sp_out == exp_sp, "R5 sp after pop", 32'(sp_out), 32'(exp_sp));
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] pc;
    logic [7:0]  last_psr;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    exp_sp = SPI;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sp_out == SPI && !busy && !done, "R1 reset during", 32'(sp_out), 32'(SPI));
    rst = 1'b0;
    @(negedge clk);
    chk(sp_out == SPI && !busy && !done && !pc_load && !psr_load && !mem_we && !mem_re,
        "R1 reset state", 32'(sp_out), 32'(SPI));

    // Sweep every status value through entry and interrupt return
    for (int p = 0; p < 256; p++) begin
      pc = {8'(p), 8'(~p), 8'(p ^ 8'h5A)};
      do_push((p % 2 == 0) ? 3'd0 : 3'd1, pc, 8'(p), 1);
      do_pop(3'd2, pc + 24'd2, 8'(p));
    end
    last_psr = 8'hFF;

    // Nested frames with wrap across address zero (R7)
    do_push(3'd3, 24'hABCDEF, 8'h77, 1);       // call: top byte 0, R4
    do_push(3'd0, 24'h123456, 8'h3C, 1);       // sp 4 -> 0
    do_push(3'd1, 24'hFFFFFF, 8'hC3, 1);       // sp 0 -> FFFFFC, R7
    chk(sp_out == 24'hFFFFFC, "R7 sp wrap down", 32'(sp_out), 32'hFFFFFC);
    chk(w_data[0] == 8'h01 && w_data[2] == 8'h00, "R7 pc+2 wrap", 32'(w_data[0]), 32'h01);
    do_pop(3'd2, 24'h000001, 8'hC3);
    chk(sp_out == 24'h000000, "R7 sp wrap up", 32'(sp_out), 32'h0);
    do_pop(3'd2, 24'h123458, 8'h3C);
    last_psr = 8'h3C;
    do_pop(3'd4, 24'hABCDEF, last_psr);        // R6

    // Commands during busy are ignored (R8)
    do_push(3'd0, 24'h000100, 8'h11, 3);
    @(negedge clk);
    chk(!busy && !mem_we && !mem_re && sp_out == exp_sp, "R8 busy strobes ignored",
        32'(sp_out), 32'(exp_sp));
    do_pop(3'd2, 24'h000102, 8'h11);

    // Undefined opcodes are ignored (R8)
    for (int op = 5; op < 8; op++) begin
      int act;
      act = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (busy || mem_we || mem_re || done) act++;
        @(negedge clk);
      end
      chk(act == 0 && sp_out == exp_sp, "R8 undefined opcode", 32'(act), 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule